// File: doc/BRIEF.md
# Beat-wise Vector Lane Predication Controller

This block drives the lane predication of a vector unit that runs each instruction as four beats in a row, numbered 0 to 3 and taken in order. It keeps a 16-bit predicate register, one 4-bit nibble per beat, and an 8-bit mask register split into two 4-bit fields. Beats 0 and 1 consult the low field and beats 2 and 3 consult the high field. For every beat it returns a 4-bit byte-lane enable. The enable is all ones when the consulted field is zero. Otherwise it is the predicate nibble that belongs to that beat.

While a beat executes, the instruction may raise a suppress input. If it does not, the block steps its predication state forward. A field of 1000 collapses to zero and a field of zero stays as it is. Any other field first inverts the current beat's predicate nibble when its top bit is set, then shifts left with a zero entering at the bottom. The shifted field is stored only on odd beats; on even beats it is dropped. Software can load either register through a synchronous write port, and such a write wins over a step in the same cycle.

Top module: `vpred_beat_ctrl`

## Requirements
- R1: During and right after reset, `pred_q` and `mask_q` are zero and `lane_vld` is low.
- R2: A beat presented with `beat_vld` high produces `lane_vld` high one clock edge later, with `lane_beat` equal to that beat's index; with no beat, `lane_vld` is low at the next edge.
- R3: Beats 0 and 1 consult `mask_q[3:0]`, and beats 2 and 3 consult `mask_q[7:4]`. When the consulted field is 0000, `lane_en` is 4'b1111.
- R4: When the consulted field is non-zero, `lane_en` equals `pred_q[4*b+3:4*b]` as it was before the beat, where b is the beat index.
- R5: A step on a field of 4'b1000 turns the field into 4'b0000 and leaves `pred_q` unchanged.
- R6: A step on a non-zero field other than 4'b1000 whose bit 3 is set inverts bits `4*b+3:4*b` of `pred_q` on every beat, odd or even, and shifts the field left by one with a zero entering bit 0.
- R7: A step on a non-zero field whose bit 3 is clear leaves `pred_q` unchanged and shifts the field left by one with a zero entering bit 0.
- R8: The stepped field is written back to `mask_q` only on beats 1 and 3. On beats 0 and 2, `mask_q` is unchanged.
- R9: A beat with `keep_state` high leaves both `pred_q` and `mask_q` unchanged.
- R10: A write (`pred_wr_en` or `mask_wr_en`) loads its data into that register at the next edge. In a cycle with a beat it overrides that register's step, while the beat's `lane_en` still comes from the state as it was before the write.
- R11: A step on a field of 0000 leaves both registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| beat_vld | input | 1 | A beat executes in this cycle |
| beat_idx | input | 2 | Index of the executing beat |
| keep_state | input | 1 | Instruction suppresses the step for this beat |
| pred_wr_en | input | 1 | Software load of the predicate register |
| pred_wr_data | input | 16 | Predicate load value |
| mask_wr_en | input | 1 | Software load of the mask register |
| mask_wr_data | input | 8 | Mask load value |
| pred_q | output | 16 | Current predicate register |
| mask_q | output | 8 | Current mask register |
| lane_en | output | 4 | Registered byte-lane enable for the last beat |
| lane_vld | output | 1 | `lane_en` belongs to a beat from the previous cycle |
| lane_beat | output | 2 | Beat index aligned with `lane_en` |

## Verification
Every result is due one clock edge after the cycle that carries the beat or the write: the registered lane enable with its beat tag, and the stepped or loaded register values. The driver applies inputs on a falling edge and queues the expected enable. It then compares both registers on the next falling edge, right after the edge that updates them. A monitor pops the queue on each falling edge where `lane_vld` is high, so every comparison falls half a cycle after the edge it depends on, and a missing or stray enable is counted as a failure.

// File: rtl/vpred_beat_ctrl.sv
module vpred_beat_ctrl #(
  parameter int LANE_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  beat_vld,
  input  logic [1:0]            beat_idx,
  input  logic                  keep_state,
  input  logic                  pred_wr_en,
  input  logic [4*LANE_W-1:0]   pred_wr_data,
  input  logic                  mask_wr_en,
  input  logic [2*LANE_W-1:0]   mask_wr_data,
  output logic [4*LANE_W-1:0]   pred_q,
  output logic [2*LANE_W-1:0]   mask_q,
  output logic [LANE_W-1:0]     lane_en,
  output logic                  lane_vld,
  output logic [1:0]            lane_beat
);
  localparam int BEATS  = 4;
  localparam int HALVES = 2;
  localparam int PRED_W = BEATS * LANE_W;
  localparam int MASK_W = HALVES * LANE_W;
  localparam logic [LANE_W-1:0] FLD_LAST = {1'b1, {(LANE_W-1){1'b0}}};

  logic [PRED_W-1:0] pred_r, pred_nxt;
  logic [MASK_W-1:0] mask_r, mask_nxt;
  logic [LANE_W-1:0] nib [BEATS];
  logic [LANE_W-1:0] fld [HALVES];
  logic [LANE_W-1:0] cur_fld, cur_nib, fld_step;
  logic              fld_zero, fld_last, step, flip, store;

  for (genvar h = 0; h < HALVES; h++) begin : g_fld
    assign fld[h] = mask_r[h*LANE_W +: LANE_W];
    assign mask_nxt[h*LANE_W +: LANE_W] =
      (store && beat_idx[1] == 1'(h)) ? fld_step : fld[h];
  end

  assign cur_fld  = fld[beat_idx[1]];
  assign fld_zero = (cur_fld == '0);
  assign fld_last = (cur_fld == FLD_LAST);
  assign step     = beat_vld && !keep_state && !fld_zero;
  assign flip     = step && !fld_last && cur_fld[LANE_W-1];
  assign store    = step && beat_idx[0];
  assign fld_step = fld_last ? '0 : {cur_fld[LANE_W-2:0], 1'b0};

  for (genvar b = 0; b < BEATS; b++) begin : g_nib
    assign nib[b] = pred_r[b*LANE_W +: LANE_W];
    assign pred_nxt[b*LANE_W +: LANE_W] =
      (flip && beat_idx == 2'(b)) ? ~nib[b] : nib[b];
  end

  assign cur_nib = nib[beat_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pred_r    <= '0;
      mask_r    <= '0;
      lane_en   <= '0;
      lane_vld  <= 1'b0;
      lane_beat <= '0;
    end else begin
      pred_r   <= pred_wr_en ? pred_wr_data : pred_nxt;
      mask_r   <= mask_wr_en ? mask_wr_data : mask_nxt;
      lane_vld <= beat_vld;
      if (beat_vld) begin
        lane_en   <= fld_zero ? '1 : cur_nib;
        lane_beat <= beat_idx;
      end
    end
  end

  assign pred_q = pred_r;
  assign mask_q = mask_r;
endmodule

// File: rtl/vpred_beat_ctrl_chk.sv
module vpred_beat_ctrl_chk #(
  parameter int LANE_W = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                beat_vld,
  input logic [1:0]          beat_idx,
  input logic                keep_state,
  input logic                pred_wr_en,
  input logic [4*LANE_W-1:0] pred_wr_data,
  input logic                mask_wr_en,
  input logic [2*LANE_W-1:0] mask_wr_data,
  input logic [4*LANE_W-1:0] pred_q,
  input logic [2*LANE_W-1:0] mask_q,
  input logic [LANE_W-1:0]   lane_en,
  input logic                lane_vld,
  input logic [1:0]          lane_beat
);
  logic [LANE_W-1:0] lo_fld;
  assign lo_fld = mask_q[LANE_W-1:0];

  AST_BEAT_TO_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    beat_vld |=> lane_vld && lane_beat == $past(beat_idx)); // R2
  AST_NO_BEAT_NO_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_vld |=> !lane_vld); // R2
  AST_ZERO_FIELD_ALL_ON: assert property (@(posedge clk) disable iff (!rst_n)
    beat_vld && !beat_idx[1] && lo_fld == '0 |=> lane_en == '1); // R3
  AST_EVEN_BEAT_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    beat_vld && !beat_idx[0] && !mask_wr_en |=> $stable(mask_q)); // R8
  AST_KEEP_PRED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    beat_vld && keep_state && !pred_wr_en |=> $stable(pred_q)); // R9
  AST_KEEP_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    beat_vld && keep_state && !mask_wr_en |=> $stable(mask_q)); // R9
  AST_PRED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    pred_wr_en |=> pred_q == $past(pred_wr_data)); // R10
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr_en |=> mask_q == $past(mask_wr_data)); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_vld && !pred_wr_en && !mask_wr_en |=> $stable(pred_q) && $stable(mask_q)); // R11
endmodule

bind vpred_beat_ctrl vpred_beat_ctrl_chk #(.LANE_W(LANE_W)) u_chk (.*);

// File: tb/test_vpred_beat_ctrl.sv
`timescale 1ns/1ps
module test_vpred_beat_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        beat_vld = 1'b0, keep_state = 1'b0, pred_wr_en = 1'b0, mask_wr_en = 1'b0;
  logic [1:0]  beat_idx = '0;
  logic [15:0] pred_wr_data = '0;
  logic [7:0]  mask_wr_data = '0;
  logic [15:0] pred_q;
  logic [7:0]  mask_q;
  logic [3:0]  lane_en;
  logic        lane_vld;
  logic [1:0]  lane_beat;

  int checks = 0, failures = 0;
  logic [15:0] m_pred = '0;
  logic [7:0]  m_mask = '0;
  logic [3:0]  q_en[$];
  logic [1:0]  q_beat[$];
  string       q_tag[$];

  always #5 clk = ~clk;

  vpred_beat_ctrl i_vpred_beat_ctrl (.*);

  task automatic check(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(negedge clk) begin
    if (rst_n && lane_vld) begin
      if (q_en.size() == 0) begin
        check("R2", "unexpected lane_vld", 16'h1, 16'h0);
      end else begin
        automatic logic [3:0] e = q_en.pop_front();
        automatic logic [1:0] b = q_beat.pop_front();
        automatic string t = q_tag.pop_front();
        check(t, "lane_en", 16'(lane_en), 16'(e));
        check("R2", "lane_beat", 16'(lane_beat), 16'(b));
      end
    end
  end

  task automatic do_beat(input logic [1:0] idx, input logic keep,
                         input logic pwe, input logic [15:0] pwd,
                         input logic mwe, input logic [7:0] mwd);
    logic [3:0] f, sl, nf;
    logic [15:0] np;
    logic [7:0] nm;
    string tg, mtg;
    f  = idx[1] ? m_mask[7:4] : m_mask[3:0];
    sl = m_pred[int'(idx)*4 +: 4];
    nf = f;
    q_en.push_back(f == 4'h0 ? 4'hF : sl);
    q_beat.push_back(idx);
    q_tag.push_back(f == 4'h0 ? "R3" : "R4");
    np = m_pred;
    nm = m_mask;
    if (keep) tg = "R9";
    else if (f == 4'h0) tg = "R11";
    else if (f == 4'b1000) begin tg = "R5"; nf = 4'h0; end
    else begin
      tg = f[3] ? "R6" : "R7";
      if (f[3]) np[int'(idx)*4 +: 4] = ~sl;
      nf = {f[2:0], 1'b0};
    end
    if (!keep && f != 4'h0 && idx[0]) begin
      if (idx[1]) nm[7:4] = nf; else nm[3:0] = nf;
    end
    mtg = (!keep && f != 4'h0 && !idx[0]) ? "R8" : tg;
    if (pwe) begin np = pwd; tg = "R10"; end
    if (mwe) begin nm = mwd; mtg = "R10"; end
    beat_vld = 1'b1; beat_idx = idx; keep_state = keep;
    pred_wr_en = pwe; pred_wr_data = pwd; mask_wr_en = mwe; mask_wr_data = mwd;
    @(negedge clk);
    beat_vld = 1'b0; keep_state = 1'b0; pred_wr_en = 1'b0; mask_wr_en = 1'b0;
    m_pred = np;
    m_mask = nm;
    check(tg, "pred_q", pred_q, m_pred);
    check(mtg, "mask_q", 16'(mask_q), 16'(m_mask));
  endtask

  task automatic sw_load(input logic [15:0] p, input logic [7:0] m);
    pred_wr_en = 1'b1; pred_wr_data = p; mask_wr_en = 1'b1; mask_wr_data = m;
    @(negedge clk);
    pred_wr_en = 1'b0; mask_wr_en = 1'b0;
    m_pred = p; m_mask = m;
    check("R10", "pred_q load", pred_q, p);
    check("R10", "mask_q load", 16'(mask_q), 16'(m));
    check("R2", "lane_vld idle", 16'(lane_vld), 16'h0);
  endtask

  task automatic run_insn(input logic [3:0] keep_bits);
    for (int b = 0; b < 4; b++) do_beat(2'(b), keep_bits[b], 1'b0, '0, 1'b0, '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check("R2", "watchdog expired", 16'h1, 16'h0);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "pred_q in reset", pred_q, 16'h0);
    check("R1", "mask_q in reset", 16'(mask_q), 16'h0);
    check("R1", "lane_vld in reset", 16'(lane_vld), 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "pred_q after reset", pred_q, 16'h0);
    check("R1", "lane_vld after reset", 16'(lane_vld), 16'h0);

    sw_load(16'h1234, 8'h00);
    run_insn(4'b0000);
    sw_load(16'hA5C3, 8'h88);
    run_insn(4'b0000);
    check("R5", "mask after 1000 fields", 16'(mask_q), 16'h0);
    sw_load(16'h0000, 8'h4C);
    run_insn(4'b0000);
    check("R6", "pred after inverting beats", pred_q, 16'h00FF);
    check("R7", "mask after shifts", 16'(mask_q), 16'h88);
    sw_load(16'h0F0F, 8'hCC);
    run_insn(4'b1111);
    check("R9", "mask after suppressed insn", 16'(mask_q), 16'hCC);
    sw_load(16'h0F0F, 8'hCC);
    do_beat(2'd0, 1'b0, 1'b1, 16'hBEEF, 1'b0, '0);
    do_beat(2'd1, 1'b0, 1'b0, '0, 1'b1, 8'h21);
    do_beat(2'd2, 1'b0, 1'b1, 16'h1357, 1'b1, 8'h30);
    do_beat(2'd3, 1'b0, 1'b0, '0, 1'b0, '0);

    for (int n = 0; n < 80; n++) begin
      automatic logic [7:0] m;
      automatic int sel0 = $urandom_range(0, 3);
      automatic int sel1 = $urandom_range(0, 3);
      m[3:0] = (sel0 == 0) ? 4'h0 : (sel0 == 1) ? 4'h8 : 4'($urandom);
      m[7:4] = (sel1 == 0) ? 4'h0 : (sel1 == 1) ? 4'h8 : 4'($urandom);
      sw_load(16'($urandom), m);
      for (int b = 0; b < 4; b++) begin
        automatic logic k = ($urandom_range(0, 3) == 0);
        automatic logic pw = ($urandom_range(0, 15) == 0);
        automatic logic mw = ($urandom_range(0, 15) == 0);
        do_beat(2'(b), k, pw, 16'($urandom), mw, 8'($urandom));
      end
    end

    repeat (2) @(negedge clk);
    check("R2", "lane results outstanding", 16'(q_en.size()), 16'h0);
    summary();
  end
endmodule